// File: doc/BRIEF.md
# Multiplexed ADC Channel Sequencer With Limit Alerts

This block drives an external multiplexed converter that has nine input channels and returns 12-bit samples. It picks which channel to convert, issues a start pulse with the channel number, waits for the converter's done strobe and stores the returned sample in that channel's result register. Every stored sample is also compared against two thresholds programmed for that channel, an upper and a lower one. A violation raises the channel's alert flag. The flag drops only once the reading has moved back inside the limit by a programmable per-channel margin, so a noisy sensor sitting on a threshold cannot make the flag chatter.

Two ways of running are offered. In on-demand mode, software writes a channel mask and then a start command, and each selected channel is converted once, lowest index first. In continuous mode, the block keeps cycling through the mask with no further commands, wrapping from the highest selected channel back to the lowest. Software then only needs to react to the single alert output, which is raised while any channel flag is set. Flags can also be cleared by software through a write-one-to-clear register.

Top module: `adc_seq_monitor`

## Requirements
- R1: After reset, adc_start and alert are 0, all alert flags and result registers read 0, every upper limit reads 4095, and every lower limit and margin reads 0.
- R2: Register map: 0x00 control (bit 0 = continuous mode, writing bit 1 = 1 starts an on-demand pass, reads return bit 0 only); 0x01 channel mask (bit c selects channel c); 0x02 alert flags (bit c = flag of channel c, writing 1 clears that flag); channel c occupies 0x10+4c (upper limit), 0x11+4c (lower limit), 0x12+4c (margin), 0x13+4c (last result, read-only). Written limits read back unchanged.
- R3: An on-demand start converts every channel in the mask exactly once, in ascending index order, and then stops. A start is ignored while a pass is in progress or continuous mode is on.
- R4: With continuous mode on and a non-empty mask, the selected channels are converted in ascending order, over and over, wrapping from the highest to the lowest selected channel. Turning continuous mode off stops conversions once the current pass ends.
- R5: With an empty mask, neither an on-demand start nor continuous mode issues any conversion.
- R6: The sample returned with adc_done is stored in the result register of the channel that was started and can be read back.
- R7: A sample greater than the channel's upper limit, or less than its lower limit, sets that channel's flag; a sample equal to a limit does not.
- R8: A flag set by the upper limit clears only when a sample satisfies sample + margin < upper limit; a flag set by the lower limit clears only when sample > lower limit + margin. Samples between the limit and these levels leave the flag set.
- R9: alert is 1 exactly when at least one channel flag is set.
- R10: Writing 1 to bit c of 0x02 clears channel c's flag; writing 0 to a bit leaves its flag unchanged.
- R11: adc_start is a one-cycle pulse carrying a channel number below 9 on adc_chan; no new start is issued until adc_done has been seen for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 12 | Register read data, combinational from rd_addr |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 4 | Channel to convert, valid with adc_start |
| adc_done | input | 1 | Converter has finished, adc_data valid |
| adc_data | input | 12 | Converted sample |
| alert | output | 1 | OR of all channel alert flags |

## Verification
The bench goes after samples that sit exactly on a limit and exactly on the release level, where an off-by-one comparison would set a flag on equality or release it one code too early or too late. It checks the order of conversions for a sparse mask and across wrap-around in continuous mode; a design that scanned from the top or restarted at channel 0 would produce a wrong channel log. It gives empty masks in both modes, where a design that fell through to a default channel would start a conversion, and it clears one flag while writing zeros for others, which exposes a clear register that acts on the whole vector.

// File: rtl/adc_seq_pkg.sv
// Package: register addresses and field codes shared by the sequencer top.
// Assumes an 8-bit register address space.
package adc_seq_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] A_MASK    = 8'h01;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 8'h02;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h10;

    // Field within a channel's four-word window
    typedef enum logic [1:0] {
        FLD_UPPER  = 2'd0,
        FLD_LOWER  = 2'd1,
        FLD_MARGIN = 2'd2,
        FLD_RESULT = 2'd3
    } ch_field_e;
endpackage

// File: rtl/adc_seq_sched.sv
// Conversion scheduler: picks the lowest pending channel, issues a one-cycle
// start pulse and waits for the converter's done strobe before the next one.
// Assumes adc_done is only asserted for a conversion that was started.
module adc_seq_sched #(
    parameter int unsigned NCH = 9,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cont_en,
    input  logic [NCH-1:0] chan_mask,
    input  logic           go,
    output logic           adc_start,
    output logic [CW-1:0]  adc_chan,
    input  logic           adc_done,
    output logic           res_valid,
    output logic [CW-1:0]  res_chan
);
    logic [NCH-1:0] pending;
    logic           busy;
    logic [NCH-1:0] cand;
    logic [CW-1:0]  sel;
    logic [NCH-1:0] sel_bit;

    // Lowest set bit of a channel vector
    function automatic logic [CW-1:0] lowest_idx(input logic [NCH-1:0] v);
        lowest_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) lowest_idx = CW'(i);
        end
    endfunction

    // Candidate set: rest of current pass, else a fresh pass in continuous mode
    always_comb begin
        cand    = (pending != '0) ? pending : (cont_en ? chan_mask : '0);
        sel     = lowest_idx(cand);
        sel_bit = {{(NCH-1){1'b0}}, 1'b1} << sel;
    end

    // Issue starts, track the in-flight conversion and the remaining pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= '0;
            busy      <= 1'b0;
            adc_start <= 1'b0;
            adc_chan  <= '0;
        end else if (!busy) begin
            if (cand != '0) begin
                adc_start <= 1'b1;
                adc_chan  <= sel;
                pending   <= cand & ~sel_bit;
                busy      <= 1'b1;
            end else if (go && !cont_en) begin
                pending <= chan_mask;
            end
        end else begin
            adc_start <= 1'b0;
            if (adc_done) busy <= 1'b0;
        end
    end

    assign res_valid = busy && adc_done;
    assign res_chan  = adc_chan;

    a_r11_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    a_r11_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (int'(adc_chan) < NCH));
    a_r11_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adc_done) |=> !adc_start);
    a_r5_empty_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pending == '0 && chan_mask == '0) |=> !adc_start);
endmodule

// File: rtl/adc_seq_limit.sv
// Per-channel limit checker: sets a flag when a sample leaves the window
// [lower, upper] and releases it only once the sample is back inside by the
// margin. Software clear acts unless a new sample arrives in the same cycle.
module adc_seq_limit #(
    parameter int unsigned DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] upper,
    input  logic [DW-1:0] lower,
    input  logic [DW-1:0] margin,
    input  logic          clr,
    output logic          flag
);
    logic          over_f, under_f;
    logic          over_n, under_n;
    logic [DW:0]   up_sum, lo_sum;

    // Extended sums so release levels never wrap
    always_comb begin
        up_sum = {1'b0, sample} + {1'b0, margin};
        lo_sum = {1'b0, lower} + {1'b0, margin};
    end

    // Next flag state: sample outcome first, software clear otherwise
    always_comb begin
        over_n  = over_f;
        under_n = under_f;
        if (res_valid) begin
            if (sample > upper)                  over_n = 1'b1;
            else if (up_sum < {1'b0, upper})     over_n = 1'b0;
            if (sample < lower)                  under_n = 1'b1;
            else if ({1'b0, sample} > lo_sum)    under_n = 1'b0;
        end else if (clr) begin
            over_n  = 1'b0;
            under_n = 1'b0;
        end
    end

    // Flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_f  <= 1'b0;
            under_f <= 1'b0;
        end else begin
            over_f  <= over_n;
            under_f <= under_n;
        end
    end

    assign flag = over_f | under_f;

    a_r7_upper_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sample > upper) |=> flag);
    a_r7_lower_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sample < lower) |=> flag);
    a_r8_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !res_valid && !clr) |=> flag);
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !res_valid) |=> !flag);
endmodule

// File: rtl/adc_seq_monitor.sv
// Top: register file (control, mask, flags, per-channel limits and results),
// the conversion scheduler and one limit checker per channel.
// Assumes NCH <= DW so the mask and flags fit in one register word.
module adc_seq_monitor
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH = 9,
    parameter int unsigned DW  = 12,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              adc_start,
    output logic [CW-1:0]     adc_chan,
    input  logic              adc_done,
    input  logic [DW-1:0]     adc_data,
    output logic              alert
);
    logic            cont_q;
    logic [NCH-1:0]  mask_q;
    logic [DW-1:0]   upper_q  [NCH];
    logic [DW-1:0]   lower_q  [NCH];
    logic [DW-1:0]   margin_q [NCH];
    logic [DW-1:0]   result_q [NCH];
    logic [NCH-1:0]  flags;
    logic [NCH-1:0]  clr_vec;
    logic            go;
    logic            res_valid;
    logic [CW-1:0]   res_chan;

    logic [ADDR_W-1:0] wr_off, rd_off;
    logic              wr_in_ch, rd_in_ch;
    int unsigned       wr_idx, rd_idx;
    ch_field_e         wr_fld, rd_fld;

    // Split addresses into channel index and field
    always_comb begin
        wr_off   = wr_addr - A_CH_BASE;
        rd_off   = rd_addr - A_CH_BASE;
        wr_idx   = int'(wr_off[ADDR_W-1:2]);
        rd_idx   = int'(rd_off[ADDR_W-1:2]);
        wr_fld   = ch_field_e'(wr_off[1:0]);
        rd_fld   = ch_field_e'(rd_off[1:0]);
        wr_in_ch = (wr_addr >= A_CH_BASE) && (wr_idx < NCH);
        rd_in_ch = (rd_addr >= A_CH_BASE) && (rd_idx < NCH);
        go       = wr_en && (wr_addr == A_CTRL) && wr_data[1];
        clr_vec  = (wr_en && wr_addr == A_FLAGS) ? wr_data[NCH-1:0] : '0;
    end

    // Control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) cont_q <= wr_data[0];
            if (wr_addr == A_MASK) mask_q <= wr_data[NCH-1:0];
        end
    end

    // Per-channel limit, margin and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                upper_q[c]  <= '1;
                lower_q[c]  <= '0;
                margin_q[c] <= '0;
                result_q[c] <= '0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_en && wr_in_ch && wr_idx == c) begin
                    case (wr_fld)
                        FLD_UPPER:  upper_q[c]  <= wr_data;
                        FLD_LOWER:  lower_q[c]  <= wr_data;
                        FLD_MARGIN: margin_q[c] <= wr_data;
                        default: ;
                    endcase
                end
                if (res_valid && int'(res_chan) == c) result_q[c] <= adc_data;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data = {{(DW-1){1'b0}}, cont_q};
        end else if (rd_addr == A_MASK) begin
            rd_data = DW'(mask_q);
        end else if (rd_addr == A_FLAGS) begin
            rd_data = DW'(flags);
        end else if (rd_in_ch) begin
            case (rd_fld)
                FLD_UPPER:  rd_data = upper_q[rd_idx];
                FLD_LOWER:  rd_data = lower_q[rd_idx];
                FLD_MARGIN: rd_data = margin_q[rd_idx];
                default:    rd_data = result_q[rd_idx];
            endcase
        end
    end

    adc_seq_sched #(.NCH(NCH)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cont_en   (cont_q),
        .chan_mask (mask_q),
        .go        (go),
        .adc_start (adc_start),
        .adc_chan  (adc_chan),
        .adc_done  (adc_done),
        .res_valid (res_valid),
        .res_chan  (res_chan)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lim
        adc_seq_limit #(.DW(DW)) u_lim (
            .clk       (clk),
            .rst_n     (rst_n),
            .res_valid (res_valid && int'(res_chan) == c),
            .sample    (adc_data),
            .upper     (upper_q[c]),
            .lower     (lower_q[c]),
            .margin    (margin_q[c]),
            .clr       (clr_vec[c]),
            .flag      (flags[c])
        );
    end

    assign alert = |flags;

    a_r6_result_captured: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (result_q[$past(res_chan)] == $past(adc_data)));
    a_r9_alert_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> ($countones(flags) > 0));
endmodule

// File: tb/tb_adc_seq_monitor.sv
// Directed bench with a behavioural converter model answering after a latency.
module tb_adc_seq_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        adc_start;
    logic [3:0]  adc_chan;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic        alert;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] vals [9];
    int conv_log [512];
    int conv_cnt = 0;
    int overlap_err = 0;
    int m_pend = 0;
    int m_cnt = 0;
    int m_ch = 0;

    adc_seq_monitor dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
        .adc_data(adc_data), .alert(alert)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: sees start, answers LAT cycles later
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (adc_start) begin
            if (m_pend != 0 || int'(adc_chan) > 8) overlap_err++;
            m_pend = 1;
            m_cnt  = LAT;
            m_ch   = int'(adc_chan);
            if (conv_cnt < 512) conv_log[conv_cnt] = m_ch;
            conv_cnt++;
        end else if (m_pend != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                adc_done = 1'b1;
                adc_data = vals[m_ch];
                m_pend   = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One on-demand conversion of a single channel
    task automatic convert_one(input int ch, input int v);
        vals[ch] = 12'(v);
        wr(8'h01, 1 << ch);
        wr(8'h00, 2);
        idle(15);
    endtask

    task automatic t_reset();
        int v;
        check(adc_start == 1'b0, "R1 adc_start", int'(adc_start), 0);
        check(alert == 1'b0, "R1 alert", int'(alert), 0);
        rd(8'h02, v); check(v == 0, "R1 flags", v, 0);
        rd(8'h10 + 4*4, v); check(v == 4095, "R1 upper ch4", v, 4095);
        rd(8'h11 + 4*4, v); check(v == 0, "R1 lower ch4", v, 0);
        rd(8'h12 + 4*8, v); check(v == 0, "R1 margin ch8", v, 0);
        rd(8'h13 + 4*2, v); check(v == 0, "R1 result ch2", v, 0);
    endtask

    task automatic t_regmap();
        int v;
        wr(8'h10 + 4*7, 3210);
        wr(8'h11 + 4*7, 123);
        wr(8'h12 + 4*7, 45);
        rd(8'h10 + 4*7, v); check(v == 3210, "R2 upper ch7", v, 3210);
        rd(8'h11 + 4*7, v); check(v == 123, "R2 lower ch7", v, 123);
        rd(8'h12 + 4*7, v); check(v == 45, "R2 margin ch7", v, 45);
        wr(8'h10 + 4*7, 4095); wr(8'h11 + 4*7, 0); wr(8'h12 + 4*7, 0);
    endtask

    task automatic t_command_pass();
        int base, v;
        int exp_seq[4] = '{0, 2, 5, 8};
        for (int c = 0; c < 9; c++) vals[c] = 12'(100 + 11*c);
        base = conv_cnt;
        wr(8'h01, 12'h125);
        wr(8'h00, 2);
        wr(8'h00, 2);   // R3: start while busy is ignored
        idle(60);
        check(conv_cnt - base == 4, "R3 pass length", conv_cnt - base, 4);
        for (int i = 0; i < 4; i++)
            check(conv_log[base+i] == exp_seq[i], "R3 ascending order", conv_log[base+i], exp_seq[i]);
        idle(30);
        check(conv_cnt - base == 4, "R3 stops after pass", conv_cnt - base, 4);
        rd(8'h13 + 4*5, v); check(v == 155, "R6 result ch5", v, 155);
        rd(8'h13 + 4*8, v); check(v == 188, "R6 result ch8", v, 188);
        rd(8'h13 + 4*1, v); check(v == 0, "R6 unselected ch1 untouched", v, 0);
        check(alert == 1'b0, "R9 no alert in window", int'(alert), 0);
    endtask

    task automatic t_empty_mask();
        int base;
        base = conv_cnt;
        wr(8'h01, 0);
        wr(8'h00, 2);
        idle(20);
        check(conv_cnt == base, "R5 empty on-demand", conv_cnt - base, 0);
        wr(8'h00, 1);
        idle(30);
        check(conv_cnt == base, "R5 empty continuous", conv_cnt - base, 0);
        wr(8'h00, 0);
    endtask

    task automatic t_limits();
        int v;
        wr(8'h10 + 4*3, 2000);
        wr(8'h11 + 4*3, 500);
        wr(8'h12 + 4*3, 100);
        convert_one(3, 2000);
        check(alert == 1'b0, "R7 equal upper no flag", int'(alert), 0);
        convert_one(3, 500);
        check(alert == 1'b0, "R7 equal lower no flag", int'(alert), 0);
        convert_one(3, 2001);
        rd(8'h02, v); check(v == 8, "R7 upper sets flag bit3", v, 8);
        check(alert == 1'b1, "R9 alert follows flag", int'(alert), 1);
        convert_one(3, 1950);
        check(alert == 1'b1, "R8 inside margin holds", int'(alert), 1);
        convert_one(3, 1900);
        check(alert == 1'b1, "R8 at release level holds", int'(alert), 1);
        convert_one(3, 1899);
        check(alert == 1'b0, "R8 below release clears", int'(alert), 0);
        convert_one(3, 499);
        check(alert == 1'b1, "R7 lower sets flag", int'(alert), 1);
        convert_one(3, 600);
        check(alert == 1'b1, "R8 low at release level holds", int'(alert), 1);
        convert_one(3, 601);
        check(alert == 1'b0, "R8 low above release clears", int'(alert), 0);
    endtask

    task automatic t_clear();
        int v;
        convert_one(3, 3000);
        check(alert == 1'b1, "R10 setup flag", int'(alert), 1);
        wr(8'h02, 12'h010);
        rd(8'h02, v); check(v == 8, "R10 zero bit keeps flag", v, 8);
        wr(8'h02, 12'h008);
        rd(8'h02, v); check(v == 0, "R10 one bit clears flag", v, 0);
        check(alert == 1'b0, "R9 alert drops", int'(alert), 0);
    endtask

    task automatic t_continuous();
        int base, n, v, after;
        int exp_seq[5] = '{1, 6, 1, 6, 1};
        wr(8'h10 + 4*6, 1000);
        vals[1] = 12'd10;
        vals[6] = 12'd1500;
        base = conv_cnt;
        wr(8'h01, 12'h042);
        wr(8'h00, 1);
        n = 0;
        while (conv_cnt < base + 6 && n < 500) begin idle(1); n++; end
        for (int i = 0; i < 5; i++)
            check(conv_log[base+i] == exp_seq[i], "R4 wrap order", conv_log[base+i], exp_seq[i]);
        check(alert == 1'b1, "R4 alert in continuous", int'(alert), 1);
        rd(8'h02, v); check(v == 64, "R4 only ch6 flagged", v, 64);
        wr(8'h00, 0);
        idle(40);
        after = conv_cnt;
        idle(40);
        check(conv_cnt == after, "R4 stops when off", conv_cnt - after, 0);
        check(overlap_err == 0, "R11 handshake respected", overlap_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 9; c++) vals[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regmap();
        t_command_pass();
        t_empty_mask();
        t_limits();
        t_clear();
        t_continuous();
        check(overlap_err == 0, "R11 no overlapping start", overlap_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule